// File: doc/BRIEF.md
# Cascaded Slice Configuration and Page-Address Assignment

This block models a chain of identical search-device slices that share one 32-bit data bus and an address-valid strobe. Every slice keeps its own instruction register, a 32-bit configuration word, a 4-bit page address and an active-low full flag. Slice 0 has the highest priority and slice N-1 the lowest. A bus cycle with the address-valid strobe high broadcasts an instruction to all slices. The next cycle with the strobe low is a data cycle, and in that cycle the latched control state runs once using the bus value.

The block is used to bring a cascade into service. A broadcast write sets the configuration word in every slice. A series of page-address commands then gives each slice a unique page, one slice per command, starting at the highest-priority slice that still reads empty. A broadcast full-flag clear returns the chain to its working state. A per-slice debug view shows each slice's configuration, page and flags.

Top module: `cascade_cfg_chain`

## Requirements
- R1: After reset, every slice holds configuration 0x0200_0000 (only bit 25, the lowest-priority marker, is set), page 0, full flag high (empty) and software mode (hw_mode low), and pa_err is low.
- R2: A cycle with addr_valid high loads bus bits 11:0 as the instruction code and bus bit 13 as the direction into every slice. The control state executes only in the first following cycle with addr_valid low. Further data cycles without a new instruction change nothing.
- R3: An instruction loaded with bus bit 13 high is a read. Its data cycle changes no slice state.
- R4: Code 0x006 (configuration write) loads all 32 data-cycle bus bits into the configuration word of every slice. The new value is visible after the clock edge of the data cycle.
- R5: On a configuration write, hw_mode of every slice becomes high if bus bits 27:26 are 00, and low otherwise.
- R6: Code 0x007 (page write) stores bus bits 3:0 in the page field of the highest-priority slice whose full flag is high. It then drives that slice's full flag low. No other slice changes.
- R7: Successive page writes fill the slices strictly in order: slice 0 first, then slice 1, and so on.
- R8: Code 0x008 (flag clear) sets every full flag high and leaves pages and configuration words unchanged.
- R9: A page write while every full flag is low changes no slice. It sets pa_err, and pa_err stays high until a reset.
- R10: Code 0x000 (software reset) puts every slice and pa_err into the R1 state.
- R11: Any other instruction code is a no-op.
- R12: rst_n is active low and synchronous. When it is sampled low at a clock edge, the R1 state is restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_valid | input | 1 | High: instruction cycle; low: data cycle |
| bus_data | input | 32 | Shared instruction/data bus |
| dbg_cfg | output | N_SLICES*32 | Configuration word of each slice, slice i at bits [32i+31:32i] |
| dbg_page | output | N_SLICES*4 | Page field of each slice, slice i at bits [4i+3:4i] |
| full_n | output | N_SLICES | Active-low full flag of each slice |
| hw_mode | output | N_SLICES | Hardware-control mode of each slice |
| pa_err | output | 1 | Sticky flag: page write with no empty slice |

## Verification
Every result is registered once. An instruction cycle at edge k and its data cycle at edge k+1 make the new state visible right after edge k+1. The bench drives inputs on the falling edge, places one idle cycle after each data cycle, and compares all outputs at the next falling edge, which falls after edge k+1. A bench model holds the expected configuration, page and flags of every slice and is updated by each scenario task. All outputs are compared against it, so any change to a slice that should not have changed is reported. Idle data cycles after a command are checked in the same way, which shows that a command runs only once.

// File: rtl/ccc_pkg.sv
// Package: shared codes and bit positions for the cascaded configuration chain.
// Assumes instruction codes occupy bus bits 11:0 and the direction bit is 13.
package ccc_pkg;
    localparam int CODE_W     = 12;
    localparam int DIR_BIT    = 13;
    localparam int LOWEST_BIT = 25;
    localparam int MODE_LO    = 26;
    localparam int MODE_HI    = 27;

    typedef enum logic [CODE_W-1:0] {
        OP_SWRST = 12'h000,
        OP_WRCFG = 12'h006,
        OP_WRPA  = 12'h007,
        OP_RSTFF = 12'h008
    } op_e;
endpackage

// File: rtl/ccc_priority.sv
// Module: ccc_priority
// Picks the highest-priority slice (index 0 first) whose active-low full flag
// reads empty. Also reports when no slice is empty. Purely combinational.
module ccc_priority #(
    parameter int N_SLICES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SLICES-1:0] full_n,
    output logic [N_SLICES-1:0] grant,
    output logic                all_full
);
    logic [N_SLICES:0] seen_empty;

    assign seen_empty[0] = 1'b0;

    // Ripple chain: a slice is granted if empty and nothing above it is empty.
    for (genvar i = 0; i < N_SLICES; i++) begin : g_chain
        assign grant[i]          = full_n[i] & ~seen_empty[i];
        assign seen_empty[i + 1] = seen_empty[i] | full_n[i];
    end

    assign all_full = ~seen_empty[N_SLICES];

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9
    grant_none_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_n == '0) |-> (grant == '0 && all_full));
endmodule

// File: rtl/ccc_slice.sv
// Module: ccc_slice
// One slice of the chain. It holds its own instruction register, configuration
// word, page field, full flag and mode flag. An instruction latched with
// addr_valid high executes once in the next cycle with addr_valid low.
// Assumes DATA_W >= 28 so that the mode and marker bits exist.
module ccc_slice
    import ccc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              grant,
    output logic [DATA_W-1:0] cfg_q,
    output logic [PAGE_W-1:0] page_q,
    output logic              full_n_q,
    output logic              hw_q,
    output logic              pa_cmd,
    output logic              swrst_cmd
);
    localparam logic [DATA_W-1:0] CFG_RST = DATA_W'(1) << LOWEST_BIT;

    logic [CODE_W-1:0] instr_q;
    logic              rd_q;
    logic              pend_q;
    logic              exec;
    logic              exec_cfg, exec_pa, exec_ff, exec_rst;

    // Decode of the latched control state, valid in the data cycle only.
    always_comb begin
        exec     = pend_q & ~addr_valid & ~rd_q;
        exec_cfg = exec && (instr_q == OP_WRCFG);
        exec_pa  = exec && (instr_q == OP_WRPA);
        exec_ff  = exec && (instr_q == OP_RSTFF);
        exec_rst = exec && (instr_q == OP_SWRST);
    end

    assign pa_cmd    = exec_pa;
    assign swrst_cmd = exec_rst;

    // State update: hardware or software reset, instruction load, execution.
    always_ff @(posedge clk) begin
        if (!rst_n || exec_rst) begin
            instr_q  <= '0;
            rd_q     <= 1'b0;
            pend_q   <= 1'b0;
            cfg_q    <= CFG_RST;
            page_q   <= '0;
            full_n_q <= 1'b1;
            hw_q     <= 1'b0;
        end else begin
            if (addr_valid) begin
                instr_q <= bus_data[CODE_W-1:0];
                rd_q    <= bus_data[DIR_BIT];
                pend_q  <= 1'b1;
            end else begin
                pend_q  <= 1'b0;
            end
            if (exec_cfg) begin
                cfg_q <= bus_data;
                hw_q  <= (bus_data[MODE_HI:MODE_LO] == 2'b00);
            end
            if (exec_pa && grant) begin
                page_q   <= bus_data[PAGE_W-1:0];
                full_n_q <= 1'b0;
            end
            if (exec_ff) begin
                full_n_q <= 1'b1;
            end
        end
    end

    // R4
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_cfg |=> (cfg_q == $past(bus_data)));

    // R6
    pa_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_pa && grant) |=> (!full_n_q && page_q == $past(bus_data[PAGE_W-1:0])));

    // R3
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && rd_q && !addr_valid) |=> ($stable(cfg_q) && $stable(page_q) && $stable(full_n_q)));

    // R10
    swrst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_rst |=> (cfg_q == CFG_RST && full_n_q && !hw_q && page_q == '0));
endmodule

// File: rtl/cascade_cfg_chain.sv
// Module: cascade_cfg_chain (top)
// A chain of N_SLICES slices on one shared bus. Slice 0 has the highest
// priority. Page writes go to the highest-priority empty slice through
// ccc_priority. A page write with no empty slice sets a sticky error.
// Assumes all slices see the same broadcast instructions.
module cascade_cfg_chain
    import ccc_pkg::*;
#(
    parameter int N_SLICES = 4,
    parameter int DATA_W   = 32,
    parameter int PAGE_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       addr_valid,
    input  logic [DATA_W-1:0]          bus_data,
    output logic [N_SLICES*DATA_W-1:0] dbg_cfg,
    output logic [N_SLICES*PAGE_W-1:0] dbg_page,
    output logic [N_SLICES-1:0]        full_n,
    output logic [N_SLICES-1:0]        hw_mode,
    output logic                       pa_err
);
    logic [N_SLICES-1:0] grant;
    logic [N_SLICES-1:0] pa_cmd_v;
    logic [N_SLICES-1:0] swrst_v;
    logic                all_full;

    ccc_priority #(.N_SLICES(N_SLICES)) u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .full_n   (full_n),
        .grant    (grant),
        .all_full (all_full)
    );

    for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
        ccc_slice #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .addr_valid (addr_valid),
            .bus_data   (bus_data),
            .grant      (grant[i]),
            .cfg_q      (dbg_cfg[i*DATA_W +: DATA_W]),
            .page_q     (dbg_page[i*PAGE_W +: PAGE_W]),
            .full_n_q   (full_n[i]),
            .hw_q       (hw_mode[i]),
            .pa_cmd     (pa_cmd_v[i]),
            .swrst_cmd  (swrst_v[i])
        );
    end

    // Sticky error for a page write that finds every slice full.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst_v[0]) begin
            pa_err <= 1'b0;
        end else if (pa_cmd_v[0] && all_full) begin
            pa_err <= 1'b1;
        end
    end

    // R9
    overflow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_cmd_v[0] && all_full) |=> (pa_err && $stable(full_n) && $stable(dbg_page)));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_err && !swrst_v[0]) |=> pa_err);

    // R7
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_cmd_v[0] && !all_full) |=> ($countones(full_n) == $countones($past(full_n)) - 1));
endmodule

// File: tb/tb_cascade_cfg_chain.sv
// Directed bench: one task per scenario. A model of the expected slice state
// is kept and every output is compared against it after each command.
module tb_cascade_cfg_chain;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int DW = 32;
    localparam int PW = 4;
    localparam logic [DW-1:0] CFG_RST = 32'h0200_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              addr_valid = 1'b0;
    logic [DW-1:0]     bus_data = '0;
    logic [N*DW-1:0]   dbg_cfg;
    logic [N*PW-1:0]   dbg_page;
    logic [N-1:0]      full_n;
    logic [N-1:0]      hw_mode;
    logic              pa_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [DW-1:0] e_cfg  [N];
    logic [PW-1:0] e_page [N];
    logic [N-1:0]  e_full_n;
    logic [N-1:0]  e_hw;
    logic          e_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_cfg_chain #(.N_SLICES(N), .DATA_W(DW), .PAGE_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .bus_data(bus_data),
        .dbg_cfg(dbg_cfg), .dbg_page(dbg_page), .full_n(full_n),
        .hw_mode(hw_mode), .pa_err(pa_err)
    );

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            e_cfg[i]  = CFG_RST;
            e_page[i] = '0;
        end
        e_full_n = '1;
        e_hw     = '0;
        e_err    = 1'b0;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < N; i++) begin
            chk(req, dbg_cfg[i*DW +: DW], e_cfg[i], $sformatf("cfg[%0d]", i));
            chk(req, DW'(dbg_page[i*PW +: PW]), DW'(e_page[i]), $sformatf("page[%0d]", i));
        end
        chk(req, DW'(full_n), DW'(e_full_n), "full_n");
        chk(req, DW'(hw_mode), DW'(e_hw), "hw_mode");
        chk(req, DW'(pa_err), DW'(e_err), "pa_err");
    endtask

    // Instruction cycle, data cycle, one idle cycle; outputs settle after the data edge.
    task automatic command(input logic [11:0] code, input bit rd, input logic [DW-1:0] data);
        @(negedge clk);
        addr_valid = 1'b1;
        bus_data   = {18'd0, rd, 1'b0, code};
        @(negedge clk);
        addr_valid = 1'b0;
        bus_data   = data;
        @(negedge clk);
        bus_data   = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check_all("R1");
    endtask

    task automatic t_cfg_write(input logic [DW-1:0] v);
        command(12'h006, 1'b0, v);
        for (int i = 0; i < N; i++) e_cfg[i] = v;
        e_hw = (v[27:26] == 2'b00) ? '1 : '0;
        check_all("R4");
        chk("R5", DW'(hw_mode), DW'(e_hw), "hw_mode after cfg write");
    endtask

    task automatic t_read_dir();
        command(12'h006, 1'b1, 32'hDEAD_BEEF);
        check_all("R3");
    endtask

    task automatic t_one_shot();
        command(12'h007, 1'b0, 32'h0000_000C);
        e_page[0] = 4'hC; e_full_n[0] = 1'b0;
        check_all("R6");
        // extra data cycles without a new instruction must do nothing
        @(negedge clk); bus_data = 32'h0000_0005;
        @(negedge clk); bus_data = 32'h0000_0003;
        @(negedge clk); bus_data = '0;
        @(negedge clk);
        check_all("R2");
    endtask

    task automatic t_page_seq();
        command(12'h007, 1'b0, 32'hFFFF_FFF9);
        e_page[1] = 4'h9; e_full_n[1] = 1'b0;
        check_all("R7");
        for (int i = 2; i < N; i++) begin
            command(12'h007, 1'b0, DW'(i + 4));
            e_page[i] = PW'(i + 4); e_full_n[i] = 1'b0;
            check_all("R7");
        end
    endtask

    task automatic t_all_full_err();
        command(12'h007, 1'b0, 32'h0000_000F);
        e_err = 1'b1;
        check_all("R9");
        command(12'h006, 1'b0, 32'h0C00_0001);
        for (int i = 0; i < N; i++) e_cfg[i] = 32'h0C00_0001;
        e_hw = '0;
        check_all("R9");
    endtask

    task automatic t_clear_full();
        command(12'h008, 1'b0, 32'h1234_5678);
        e_full_n = '1;
        check_all("R8");
        command(12'h007, 1'b0, 32'h0000_0002);
        e_page[0] = 4'h2; e_full_n[0] = 1'b0;
        check_all("R8");
    endtask

    task automatic t_nop_code();
        command(12'h055, 1'b0, 32'hFFFF_FFFF);
        check_all("R11");
        command(12'h016, 1'b0, 32'hAAAA_AAAA);
        check_all("R11");
    endtask

    task automatic t_sw_reset();
        command(12'h000, 1'b0, 32'h0);
        model_reset();
        check_all("R10");
    endtask

    task automatic t_hw_reset();
        command(12'h006, 1'b0, 32'h0000_0077);
        command(12'h007, 1'b0, 32'h0000_0001);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_all("R12");
    endtask

    initial begin
        t_reset();
        t_cfg_write(32'h0300_00A5);
        t_cfg_write(32'h0000_1234);
        t_read_dir();
        t_one_shot();
        t_page_seq();
        t_all_full_err();
        t_clear_full();
        t_nop_code();
        t_sw_reset();
        t_hw_reset();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule